// File: doc/BRIEF.md
# Vectored Interrupt Controller, 64 Sources

This block gathers 64 level-sensitive interrupt lines and turns them into two processor requests: a normal request and a fast request. Software uses a 32-bit register bus to enable or disable each line, to force it high, to send it to either the normal or the fast path, and to give it a 4-bit priority. A per-line flag selects the path. Each group of 64 per-line bits is split across a pair of 32-bit registers. Lines 0–31 sit in the low register at their own bit position. Lines 32–63 sit in the high register at bit (line − 32).

For the normal path, the block picks the pending line with the highest priority. When two lines have the same priority, the higher line number wins. The winner's number and priority can be read from a vector/status word, and all-ones in the number field means no normal line is pending. The normal request is raised only when the winning priority is strictly above a programmable mask level. For the fast path, the fast request is the OR of all fast-pending lines, and a second status word names the highest-numbered fast-pending line. Raw line levels, force bits and both pending sets can be read back as low/high register pairs.

The input lines are captured in a register on every clock. The request outputs and the pending state therefore follow a line change one clock later. Register reads return their data one clock after the read request.

Top module: `vic64_ctrl`

## Requirements
- R1: After reset, the following hold: enable, type and force bits are all 0; the mask level reads 0x1F; the control word reads 0; both request outputs are low; both vector/status words read 0xFFFF0000.
- R2: Bit b of the low register of a pair is line b. Bit b of the high register is line b+32. This holds for enable (high 0x10, low 0x14), type (0x18/0x1C), force (0x50/0x54), raw line (0x48/0x4C), normal pending (0x58/0x5C) and fast pending (0x60/0x64).
- R3: A line is normal-pending when (line level OR force bit) AND enable is 1 and its type bit is 0. It is fast-pending under the same rule with type bit 1. A line whose enable is 0 is never pending.
- R4: Writing a value n below 64 to 0x08 sets enable bit n. Writing n to 0x0C clears enable bit n. Values of 64 or above leave every enable bit unchanged.
- R5: There are eight priority words. Word x sits at byte address 0x20 + 4·(7 − x) and holds lines 8x..8x+7. Line 8x+k uses bits 4k+3..4k. Word 0 is therefore at 0x3C and word 7 at 0x20.
- R6: The normal vector/status word at 0x40 carries the winning line number in bits 31..16 and the winning priority in bits 3..0. On a priority tie, the higher line number wins. With nothing normal-pending, the word reads 0xFFFF0000.
- R7: The normal request output is high exactly when some line is normal-pending and the winning priority is strictly greater than the 5-bit mask level at 0x04. A mask level of 15 or more blocks the request but leaves the vector word unchanged.
- R8: The fast request output is high exactly when some line is fast-pending. The fast vector/status word at 0x44 carries the highest-numbered fast-pending line in bits 31..16, and reads 0xFFFF0000 when no line is fast-pending.
- R9: A set force bit makes its line act as asserted, even when the input line is low. The raw line register still shows the input level.
- R10: The control word at 0x00 stores any 32-bit value. A read presents its data on the read-data port one clock after the read request. Addresses 0x08 and 0x0C read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| src_lines | input | 64 | Level-sensitive interrupt lines |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The assertions assume the following about the inputs. Each bus access lasts a single cycle. The bus address is word aligned. The reset is synchronous and is held long enough for the registered state to settle. The bench meets these assumptions as follows. It drives every access for exactly one cycle between falling edges and uses only aligned register addresses. It changes the interrupt lines only on falling edges. In its random phase it rewrites every configuration register before the lines change, so the model it checks against always matches a fully known state.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned N_SRC      = 64;
    localparam int unsigned HALF       = N_SRC / 2;
    localparam int unsigned PRIO_W     = 4;
    localparam int unsigned MASK_W     = 5;
    localparam int unsigned IDX_W      = $clog2(N_SRC);
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned PRIO_BITS  = N_SRC * PRIO_W;

    localparam logic [6:0] A_CTRL = 7'h00;
    localparam logic [6:0] A_MASK = 7'h04;
    localparam logic [6:0] A_ENUM = 7'h08;
    localparam logic [6:0] A_DNUM = 7'h0C;
    localparam logic [6:0] A_ENH  = 7'h10;
    localparam logic [6:0] A_ENL  = 7'h14;
    localparam logic [6:0] A_TYH  = 7'h18;
    localparam logic [6:0] A_TYL  = 7'h1C;
    localparam logic [6:0] A_NVEC = 7'h40;
    localparam logic [6:0] A_FVEC = 7'h44;
    localparam logic [6:0] A_SRCH = 7'h48;
    localparam logic [6:0] A_SRCL = 7'h4C;
    localparam logic [6:0] A_FRCH = 7'h50;
    localparam logic [6:0] A_FRCL = 7'h54;
    localparam logic [6:0] A_NPH  = 7'h58;
    localparam logic [6:0] A_NPL  = 7'h5C;
    localparam logic [6:0] A_FPH  = 7'h60;
    localparam logic [6:0] A_FPL  = 7'h64;

    typedef struct packed {
        logic [WORD_W-1:0]    ctrl;
        logic [MASK_W-1:0]    mask;
        logic [N_SRC-1:0]     en;
        logic [N_SRC-1:0]     typ;
        logic [N_SRC-1:0]     frc;
        logic [N_SRC-1:0]     src;
        logic [PRIO_BITS-1:0] prio;
        logic [WORD_W-1:0]    rdata;
    } regs_t;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [6:0]           bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic [N_SRC-1:0]     src_in,
    input  logic [N_SRC-1:0]     npend,
    input  logic [N_SRC-1:0]     fpend,
    input  logic [WORD_W-1:0]    nvec_word,
    input  logic [WORD_W-1:0]    fvec_word,
    output logic [N_SRC-1:0]     en_o,
    output logic [N_SRC-1:0]     typ_o,
    output logic [N_SRC-1:0]     frc_o,
    output logic [N_SRC-1:0]     src_o,
    output logic [PRIO_BITS-1:0] prio_o,
    output logic [MASK_W-1:0]    mask_o,
    output logic [WORD_W-1:0]    rdata_o
);
    localparam logic [MASK_W-1:0] MASK_RST = '1;

    regs_t r_d, r_q;

    logic       is_prio;
    logic [2:0] prio_word;
    logic       num_ok;
    logic [WORD_W-1:0] rd_mux;

    always_comb begin
        is_prio   = (bus_addr[6:5] == 2'b01) && (bus_addr[1:0] == 2'b00);
        prio_word = 3'd7 - bus_addr[4:2];
        num_ok    = (bus_wdata < WORD_W'(N_SRC));

        rd_mux = '0;
        if (is_prio) begin
            rd_mux = r_q.prio[{prio_word, 5'b0} +: WORD_W];
        end else begin
            case (bus_addr)
                A_CTRL: rd_mux = r_q.ctrl;
                A_MASK: rd_mux = WORD_W'(r_q.mask);
                A_ENH:  rd_mux = r_q.en[N_SRC-1:HALF];
                A_ENL:  rd_mux = r_q.en[HALF-1:0];
                A_TYH:  rd_mux = r_q.typ[N_SRC-1:HALF];
                A_TYL:  rd_mux = r_q.typ[HALF-1:0];
                A_NVEC: rd_mux = nvec_word;
                A_FVEC: rd_mux = fvec_word;
                A_SRCH: rd_mux = r_q.src[N_SRC-1:HALF];
                A_SRCL: rd_mux = r_q.src[HALF-1:0];
                A_FRCH: rd_mux = r_q.frc[N_SRC-1:HALF];
                A_FRCL: rd_mux = r_q.frc[HALF-1:0];
                A_NPH:  rd_mux = npend[N_SRC-1:HALF];
                A_NPL:  rd_mux = npend[HALF-1:0];
                A_FPH:  rd_mux = fpend[N_SRC-1:HALF];
                A_FPL:  rd_mux = fpend[HALF-1:0];
                default: rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        r_d     = r_q;
        r_d.src = src_in;
        if (bus_valid && !bus_write) begin
            r_d.rdata = rd_mux;
        end
        if (bus_valid && bus_write) begin
            if (is_prio) begin
                r_d.prio[{prio_word, 5'b0} +: WORD_W] = bus_wdata;
            end else begin
                case (bus_addr)
                    A_CTRL: r_d.ctrl = bus_wdata;
                    A_MASK: r_d.mask = bus_wdata[MASK_W-1:0];
                    A_ENUM: if (num_ok) r_d.en[bus_wdata[IDX_W-1:0]] = 1'b1;
                    A_DNUM: if (num_ok) r_d.en[bus_wdata[IDX_W-1:0]] = 1'b0;
                    A_ENH:  r_d.en[N_SRC-1:HALF]  = bus_wdata;
                    A_ENL:  r_d.en[HALF-1:0]      = bus_wdata;
                    A_TYH:  r_d.typ[N_SRC-1:HALF] = bus_wdata;
                    A_TYL:  r_d.typ[HALF-1:0]     = bus_wdata;
                    A_FRCH: r_d.frc[N_SRC-1:HALF] = bus_wdata;
                    A_FRCL: r_d.frc[HALF-1:0]     = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= MASK_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign en_o    = r_q.en;
    assign typ_o   = r_q.typ;
    assign frc_o   = r_q.frc;
    assign src_o   = r_q.src;
    assign prio_o  = r_q.prio;
    assign mask_o  = r_q.mask;
    assign rdata_o = r_q.rdata;

    // R4: enable-by-number sets the addressed bit
    p_enum_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_ENUM && bus_wdata < 32'd64)
        |=> r_q.en[$past(bus_wdata[IDX_W-1:0])]);

    // R4: disable-by-number clears the addressed bit
    p_dnum_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_DNUM && bus_wdata < 32'd64)
        |=> !r_q.en[$past(bus_wdata[IDX_W-1:0])]);

    // R4: out-of-range numbers leave the enables alone
    p_num_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_addr == A_ENUM || bus_addr == A_DNUM)
         && bus_wdata >= 32'd64)
        |=> $stable(r_q.en));
endmodule

// File: rtl/vic_norm_arb.sv
module vic_norm_arb
    import vic_pkg::*;
(
    input  logic [N_SRC-1:0]     pend,
    input  logic [PRIO_BITS-1:0] prio,
    output logic                 found,
    output logic [IDX_W-1:0]     idx,
    output logic [PRIO_W-1:0]    level
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        level = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && (!found || prio[i*PRIO_W +: PRIO_W] >= level)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                level = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/vic_fast_pick.sv
module vic_fast_pick
    import vic_pkg::*;
(
    input  logic [N_SRC-1:0] pend,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic64_ctrl.sv
module vic64_ctrl
    import vic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [6:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [63:0] src_lines,
    output logic        irq_norm,
    output logic        irq_fast
);
    localparam logic [15:0] NONE = 16'hFFFF;

    logic [N_SRC-1:0]     en_q, typ_q, frc_q, src_q;
    logic [PRIO_BITS-1:0] prio_q;
    logic [MASK_W-1:0]    mask_q;
    logic [N_SRC-1:0]     live, npend, fpend;
    logic                 n_found, f_found;
    logic [IDX_W-1:0]     n_idx, f_idx;
    logic [PRIO_W-1:0]    n_level;
    logic [WORD_W-1:0]    nvec_word, fvec_word;

    always_comb begin
        live  = src_q | frc_q;
        npend = live & en_q & ~typ_q;
        fpend = live & en_q & typ_q;
    end

    vic_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .src_in    (src_lines),
        .npend     (npend),
        .fpend     (fpend),
        .nvec_word (nvec_word),
        .fvec_word (fvec_word),
        .en_o      (en_q),
        .typ_o     (typ_q),
        .frc_o     (frc_q),
        .src_o     (src_q),
        .prio_o    (prio_q),
        .mask_o    (mask_q),
        .rdata_o   (bus_rdata)
    );

    vic_norm_arb i_narb (
        .pend  (npend),
        .prio  (prio_q),
        .found (n_found),
        .idx   (n_idx),
        .level (n_level)
    );

    vic_fast_pick i_fpick (
        .pend  (fpend),
        .found (f_found),
        .idx   (f_idx)
    );

    always_comb begin
        nvec_word = n_found
            ? {{(16-IDX_W){1'b0}}, n_idx, {(16-PRIO_W){1'b0}}, n_level}
            : {NONE, 16'h0000};
        fvec_word = f_found
            ? {{(16-IDX_W){1'b0}}, f_idx, 16'h0000}
            : {NONE, 16'h0000};
        irq_norm  = n_found && ({1'b0, n_level} > mask_q);
        irq_fast  = |fpend;
    end

    // R6: the reported winner is itself normal-pending
    p_win_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        n_found |-> npend[n_idx]);

    // R7: a normal request implies a valid vector
    p_norm_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> (nvec_word[31:16] != NONE));

    // R8: the fast request agrees with the fast vector
    p_fast_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast == (fvec_word[31:16] != NONE));

    // R3: no line is pending on both paths at once
    p_path_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (npend & fpend) == '0);
endmodule

// File: tb/test_vic64_ctrl.sv
module test_vic64_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_lines = '0;
    logic        irq_norm, irq_fast;

    int errors = 0;
    int checks = 0;

    logic [63:0] m_en, m_typ, m_frc, m_src;
    logic [3:0]  m_prio [64];
    logic [4:0]  m_mask;

    always #2 clk = ~clk;

    vic64_ctrl i_vic64_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_lines(src_lines), .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic drive_src(input logic [63:0] v);
        @(negedge clk);
        src_lines = v;
        @(negedge clk);
    endtask

    function automatic logic [63:0] m_live();
        return m_src | m_frc;
    endfunction

    function automatic logic [31:0] m_nvec();
        logic [63:0] p = m_live() & m_en & ~m_typ;
        int best = -1;
        int who = 0;
        for (int s = 0; s < 64; s++)
            if (p[s] && int'(m_prio[s]) >= best) begin best = int'(m_prio[s]); who = s; end
        if (best < 0) return 32'hFFFF0000;
        return {16'(who), 16'(best)};
    endfunction

    function automatic logic [31:0] m_fvec();
        logic [63:0] p = m_live() & m_en & m_typ;
        logic [31:0] r = 32'hFFFF0000;
        for (int s = 0; s < 64; s++)
            if (p[s]) r = {16'(s), 16'h0};
        return r;
    endfunction

    function automatic logic m_irqn();
        logic [31:0] v = m_nvec();
        return (v[31:16] != 16'hFFFF) && ({1'b0, v[3:0]} > m_mask);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_norm", {31'b0, irq_norm}, 32'h0);
        check("R1 irq_fast", {31'b0, irq_fast}, 32'h0);
        rd_chk("R1 enl", 7'h14, 32'h0);
        rd_chk("R1 enh", 7'h10, 32'h0);
        rd_chk("R1 tyl", 7'h1C, 32'h0);
        rd_chk("R1 tyh", 7'h18, 32'h0);
        rd_chk("R1 frcl", 7'h54, 32'h0);
        rd_chk("R1 mask", 7'h04, 32'h1F);
        rd_chk("R1 ctrl", 7'h00, 32'h0);
        rd_chk("R1 nvec", 7'h40, 32'hFFFF0000);
        rd_chk("R1 fvec", 7'h44, 32'hFFFF0000);

        // R10 control storage and one-cycle read
        wr(7'h00, 32'hA5A5_0001);
        rd_chk("R10 ctrl", 7'h00, 32'hA5A5_0001);
        rd_chk("R10 enum reads 0", 7'h08, 32'h0);

        // R4 and R2 enable by number
        wr(7'h08, 32'd5);
        rd_chk("R4 set 5", 7'h14, 32'h0000_0020);
        wr(7'h08, 32'd40);
        rd_chk("R2 set 40 high", 7'h10, 32'h0000_0100);
        wr(7'h08, 32'd64);
        wr(7'h08, 32'd200);
        rd_chk("R4 64 ignored low", 7'h14, 32'h0000_0020);
        rd_chk("R4 64 ignored high", 7'h10, 32'h0000_0100);
        wr(7'h0C, 32'd5);
        rd_chk("R4 clr 5", 7'h14, 32'h0);
        wr(7'h0C, 32'd72);
        rd_chk("R4 clr 72 ignored", 7'h10, 32'h0000_0100);

        // R5 reverse layout, R6 winner
        wr(7'h10, 32'h8000_0000);
        wr(7'h14, 32'h0000_0003);
        wr(7'h04, 32'h0);
        wr(7'h3C, 32'h0000_0090);
        wr(7'h20, 32'h3000_0000);
        drive_src(64'h8000_0000_0000_0003);
        rd_chk("R5 word0 at 3C", 7'h3C, 32'h0000_0090);
        rd_chk("R5 word7 at 20", 7'h20, 32'h3000_0000);
        rd_chk("R6 nvec prio9", 7'h40, 32'h0001_0009);
        check("R7 irq_norm mask0", {31'b0, irq_norm}, 32'h1);
        wr(7'h20, 32'h9000_0000);
        rd_chk("R6 tie high wins", 7'h40, 32'h003F_0009);
        rd_chk("R2 srch", 7'h48, 32'h8000_0000);
        rd_chk("R3 nph", 7'h58, 32'h8000_0000);

        // R7 mask gate
        wr(7'h04, 32'd9);
        check("R7 equal blocks", {31'b0, irq_norm}, 32'h0);
        wr(7'h04, 32'd8);
        check("R7 below passes", {31'b0, irq_norm}, 32'h1);
        wr(7'h04, 32'h1F);
        check("R7 1F blocks", {31'b0, irq_norm}, 32'h0);
        rd_chk("R7 vec kept", 7'h40, 32'h003F_0009);

        // R8 fast path
        wr(7'h1C, 32'h0000_0003);
        check("R8 irq_fast", {31'b0, irq_fast}, 32'h1);
        rd_chk("R8 fvec", 7'h44, 32'h0001_0000);
        rd_chk("R8 fpl", 7'h60 + 7'h04, 32'h0000_0003);
        rd_chk("R3 npl empty", 7'h5C, 32'h0);

        // R9 force
        drive_src(64'h0);
        rd_chk("R3 nvec none", 7'h40, 32'hFFFF0000);
        check("R8 fast low", {31'b0, irq_fast}, 32'h0);
        wr(7'h54, 32'h0000_0001);
        check("R9 forced fast", {31'b0, irq_fast}, 32'h1);
        rd_chk("R9 fvec forced", 7'h44, 32'h0000_0000);
        rd_chk("R9 srcl raw", 7'h4C, 32'h0);

        // R3 disabled line never pending
        wr(7'h0C, 32'd0);
        check("R3 disabled", {31'b0, irq_fast}, 32'h0);

        // random phase
        for (int it = 0; it < 250; it++) begin
            logic [31:0] w;
            m_en  = {$urandom, $urandom};
            m_typ = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            m_frc = ($urandom % 4 == 0) ? {$urandom & $urandom, $urandom & $urandom} : 64'h0;
            m_mask = 5'($urandom % 20);
            m_src = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            if (it % 16 == 0) m_src = 64'h0;
            wr(7'h14, m_en[31:0]);  wr(7'h10, m_en[63:32]);
            wr(7'h1C, m_typ[31:0]); wr(7'h18, m_typ[63:32]);
            wr(7'h54, m_frc[31:0]); wr(7'h50, m_frc[63:32]);
            wr(7'h04, 32'(m_mask));
            for (int x = 0; x < 8; x++) begin
                w = (it % 5 == 0) ? 32'h7777_7777 : $urandom;
                for (int k = 0; k < 8; k++) m_prio[8*x+k] = w[4*k +: 4];
                wr(7'h20 + 7'(4*(7-x)), w);
            end
            drive_src(m_src);
            check("R7 rand irq_norm", {31'b0, irq_norm}, {31'b0, m_irqn()});
            check("R8 rand irq_fast", {31'b0, irq_fast}, {31'b0, |(m_live() & m_en & m_typ)});
            rd_chk("R6 rand nvec", 7'h40, m_nvec());
            rd_chk("R8 rand fvec", 7'h44, m_fvec());
            rd_chk("R3 rand npl", 7'h5C, 32'(m_live() & m_en & ~m_typ));
            rd_chk("R3 rand fph", 7'h60, 32'((m_live() & m_en & m_typ) >> 32));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule